// File: doc/BRIEF.md
# Parallel-Load Shift Register with J-K Serial Head

This block is a short synchronous register with a parallel data port and a serial shift path. At each rising clock edge a single mode control picks one of two operations. In load mode every stage copies its own parallel data bit. In shift mode the contents move one place from the head stage toward the last stage.

During a shift the head stage takes its new value from a pair of serial control inputs. These act like a J-K flip-flop whose K input is active-low, so the head can be cleared, set, held or inverted. The last stage is driven out both true and inverted.

An active-low clear acts at once, with no clock needed, and wins over every other input. It is a raw asynchronous reset: the first clock edge after it is released already loads or shifts as usual. Stage 0 is the head and stage WIDTH-1 is the last stage. Parallel bit i feeds stage i.

Top module: `jk_shift_reg`

## Requirements
- R1: While clr_n is 0, every bit of q is 0 and q_last_n is 1. This takes effect immediately, without waiting for a clock edge, and holds across any edges that occur while clr_n stays low, whatever the other inputs are.
- R2: With clr_n at 1 and no rising clock edge, q and q_last_n keep their values even when the data and control inputs change.
- R3: A rising edge with shift_en at 0 loads par_d[i] into q[i] for every stage i.
- R4: During a load (shift_en at 0), ser_j and ser_kn have no effect on any stage.
- R5: A rising edge with shift_en at 1 loads the old q[i-1] into q[i] for every i from 1 to WIDTH-1.
- R6: During a shift with ser_j=0 and ser_kn=1, q[0] keeps its old value.
- R7: During a shift with ser_j=0 and ser_kn=0, q[0] becomes 0.
- R8: During a shift with ser_j=1 and ser_kn=1, q[0] becomes 1.
- R9: During a shift with ser_j=1 and ser_kn=0, q[0] becomes the complement of its old value.
- R10: q_last_n is always the complement of q[WIDTH-1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all operations happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low; overrides everything |
| shift_en | input | 1 | 1 selects shift, 0 selects parallel load |
| ser_j | input | 1 | Serial J input for the head stage |
| ser_kn | input | 1 | Serial K input for the head stage, active low |
| par_d | input | WIDTH | Parallel load data; bit i goes to stage i |
| q | output | WIDTH | Register contents; bit 0 is the head stage |
| q_last_n | output | 1 | Inverted copy of q[WIDTH-1] |

## Verification
On every clock edge taken outside clear, the assertions check four things:
- a load copies the data port and ignores the serial pair;
- the tail stages take their neighbour's old value during a shift;
- the head stage follows each of the four J-K actions.

Three behaviours appear only in the bench's scenarios: the clear that acts in the middle of a cycle, outputs that hold steady while inputs change between edges, and the inverted last output. The bench sweeps every starting state of the 4-bit register against every serial pair and every load word. It then runs a long random sequence with occasional clears against its own model.

// File: rtl/jks_pkg.sv
package jks_pkg;

  // Serial head action, indexed by {ser_j, ser_kn}
  typedef enum logic [1:0] {
    HEAD_ZERO = 2'b00,
    HEAD_KEEP = 2'b01,
    HEAD_FLIP = 2'b10,
    HEAD_ONE  = 2'b11
  } head_op_e;

  function automatic head_op_e decode_head(input logic j, input logic kn);
    return head_op_e'({j, kn});
  endfunction

  function automatic logic head_next(input head_op_e op, input logic cur);
    logic r;
    case (op)
      HEAD_ZERO: r = 1'b0;
      HEAD_KEEP: r = cur;
      HEAD_FLIP: r = ~cur;
      default:   r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/jks_head.sv
module jks_head
  import jks_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic shift_en,
  input  logic ser_j,
  input  logic ser_kn,
  input  logic load_bit,
  output logic q_head
);

  head_op_e head_op;
  logic     head_shift_val;

  assign head_op        = decode_head(ser_j, ser_kn);
  assign head_shift_val = head_next(head_op, q_head);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q_head <= 1'b0;
    else        q_head <= shift_en ? head_shift_val : load_bit;
  end

  assert_head_keep_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && !ser_j && ser_kn) |=> (q_head == $past(q_head)));

  assert_head_zero_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && !ser_j && !ser_kn) |=> (q_head == 1'b0));

  assert_head_one_R8: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && ser_j && ser_kn) |=> (q_head == 1'b1));

  assert_head_flip_R9: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && ser_j && !ser_kn) |=> (q_head != $past(q_head)));

endmodule

// File: rtl/jks_tail.sv
module jks_tail #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_en,
  input  logic             q_head,
  input  logic [WIDTH-1:1] load_bits,
  output logic [WIDTH-1:1] q_tail
);

  localparam int TAIL_LEN = WIDTH - 1;

  logic [WIDTH-1:0] chain_prev;
  assign chain_prev = {q_tail, q_head};

  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    logic stage_q;
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) stage_q <= 1'b0;
      else        stage_q <= shift_en ? chain_prev[i-1] : load_bits[i];
    end
    assign q_tail[i] = stage_q;
  end

  assert_tail_move_R5: assert property (@(posedge clk) disable iff (!clr_n)
    shift_en |=> (q_tail == $past(chain_prev[TAIL_LEN-1:0])));

endmodule

// File: rtl/jk_shift_reg.sv
module jk_shift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_en,
  input  logic             ser_j,
  input  logic             ser_kn,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] q,
  output logic             q_last_n
);

  logic             q_head;
  logic [WIDTH-1:1] q_tail;
  logic             load_evt;

  assign load_evt = !shift_en;

  jks_head u_head (
    .clk      (clk),
    .clr_n    (clr_n),
    .shift_en (shift_en),
    .ser_j    (ser_j),
    .ser_kn   (ser_kn),
    .load_bit (par_d[0]),
    .q_head   (q_head)
  );

  jks_tail #(.WIDTH(WIDTH)) u_tail (
    .clk       (clk),
    .clr_n     (clr_n),
    .shift_en  (shift_en),
    .q_head    (q_head),
    .load_bits (par_d[WIDTH-1:1]),
    .q_tail    (q_tail)
  );

  assign q        = {q_tail, q_head};
  assign q_last_n = ~q[WIDTH-1];

  assert_load_capture_R3: assert property (@(posedge clk) disable iff (!clr_n)
    load_evt |=> (q == $past(par_d)));

  // serial pair that would flip the head is ignored while loading
  assert_load_ignores_serial_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_evt && ser_j && !ser_kn) |=> (q[0] == $past(par_d[0])));

endmodule

// File: tb/jk_shift_reg_test.sv
module jk_shift_reg_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr_n;
  logic         shift_en;
  logic         ser_j;
  logic         ser_kn;
  logic [W-1:0] par_d;
  logic [W-1:0] q;
  logic         q_last_n;

  int     n_checks = 0;
  int     n_errors = 0;
  bit     finished = 1'b0;
  logic [W-1:0] m;

  always #4 clk = ~clk;

  jk_shift_reg #(.WIDTH(W)) uut (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .ser_j(ser_j),
    .ser_kn(ser_kn), .par_d(par_d), .q(q), .q_last_n(q_last_n)
  );

  // Model: a load copies the word, a shift doubles it and adds the head bit
  function automatic logic [W-1:0] model_next(input logic [W-1:0] cur, input logic sh,
                                              input logic j, input logic kn,
                                              input logic [W-1:0] d);
    logic h;
    if (!sh) return d;
    if (j && kn)       h = 1'b1;
    else if (!j && !kn) h = 1'b0;
    else if (j)        h = !cur[0];
    else               h = cur[0];
    return W'((cur * 2) | W'(h));
  endfunction

  task automatic chk(input string req);
    logic [W:0] act, exp;
    act = {q_last_n, q};
    exp = {!m[W-1], m};
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic sh, input logic j, input logic kn, input logic [W-1:0] d);
    shift_en = sh; ser_j = j; ser_kn = kn; par_d = d;
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    if (!clr_n) m = '0;
    else        m = model_next(m, shift_en, ser_j, ser_kn, par_d);
    @(negedge clk);
    chk(req);
  endtask

  function automatic string jk_tag(input logic j, input logic kn);
    if (!j && kn)  return "R6";
    if (!j && !kn) return "R7";
    if (j && kn)   return "R8";
    return "R9";
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    clr_n = 1'b0;
    m = '0;
    drive(1'b0, 1'b1, 1'b0, 4'hF);
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset state");
    clr_n = 1'b1;

    // R3 / R4: every load word with every serial pair
    for (int d = 0; d < 16; d++) begin
      for (int jk = 0; jk < 4; jk++) begin
        drive(1'b0, jk[1], jk[0], W'(d));
        tick(jk == 0 ? "R3" : "R4");
      end
    end

    // R5..R9: every starting state with every serial pair
    for (int s = 0; s < 16; s++) begin
      for (int jk = 0; jk < 4; jk++) begin
        drive(1'b0, 1'b0, 1'b0, W'(s));
        tick("R3");
        drive(1'b1, jk[1], jk[0], W'($urandom));
        tick(jk_tag(jk[1], jk[0]));
        tick("R5");
      end
    end

    // R9: repeated toggling from zero
    drive(1'b0, 1'b0, 1'b0, 4'h0);
    tick("R3");
    for (int k = 0; k < 6; k++) begin
      drive(1'b1, 1'b1, 1'b0, 4'hF);
      tick("R9");
    end

    // R2: inputs change between edges, outputs hold
    drive(1'b0, 1'b0, 1'b1, 4'hA);
    tick("R3");
    drive(1'b1, 1'b1, 1'b1, 4'h5);
    #2 chk("R2");
    drive(1'b0, 1'b1, 1'b0, 4'h3);
    #1 chk("R2");

    // R1: clear in the middle of a cycle, then an edge while held low
    drive(1'b0, 1'b0, 1'b0, 4'hF);
    tick("R3");
    #1 clr_n = 1'b0;
    m = '0;
    #1 chk("R1 mid-cycle");
    @(posedge clk);
    @(negedge clk);
    chk("R1 overrides load");
    clr_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 4'h9);
    tick("R3 after clear");

    // R10 and all: random sequence with occasional clears
    for (int k = 0; k < 3000; k++) begin
      drive(1'($urandom), 1'($urandom), 1'($urandom), W'($urandom));
      clr_n = ($urandom % 20) != 0;
      if (!clr_n) m = '0;
      tick("R10 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule